// File: doc/BRIEF.md
# UART Receive Character Timeout Detector

This block watches the receive FIFO of a UART and raises a character-timeout flag when characters are waiting but the line has gone quiet. It measures the quiet time with a down-counter. The counter runs on a tick that comes eight times per bit time. The counter restarts whenever a character enters or leaves the FIFO. When the counter runs out while the FIFO is not empty, the flag is set. The flag goes to the interrupt identification logic. It lets software collect a partial batch of characters that never reached the programmed trigger level.

The idle window is not a fixed length. It is made of two parts. The first part depends on the character width: ((bits × 7) − 2) × 8 ticks. The second part is (trigger − occupancy) × 8 + 1 ticks. The difference in the second part is clamped at zero when the occupancy is at or above the trigger. This gives a window of roughly three and a half to four and a half character times. A FIFO that is far below its trigger waits longer before it asks for service. The flag stays set until the receive data register is read.

Top module: `rx_char_timeout`

## Requirements
- R1: After reset, `char_timeout` is 0 and the window counter is idle at zero.
- R2: The window in ticks is W = ((5 + wlen_sel) × 7 − 2) × 8 + max(trig_level − rx_level, 0) × 8 + 1. Here `wlen_sel` codes 0..3 select 5..8 data bits. The `rx_level` and `trig_level` values used are the ones present in the push or pop cycle.
- R3: After the last push or pop, the flag rises at the clock edge of the W-th cycle that has `baud_tick8` high, and not earlier. Cycles without a tick leave the counter unchanged.
- R4: A push or a pop reloads the window, which discards all ticks already counted.
- R5: While `rx_level` is 0, the counter is held at zero even when a push or pop occurs in the same cycle, and the flag cannot become set.
- R6: A cycle with `data_read` high clears the flag at that edge. The clear wins over a timeout that expires in the same cycle.
- R7: Once set, the flag stays set until `data_read`, even if `rx_level` changes without a read.
- R8: An expired window gives one indication only. After the flag is cleared, it does not come back until a new push or pop starts a new window that also runs out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | A character is written into the RX FIFO this cycle |
| rx_pop | input | 1 | A character is removed from the RX FIFO this cycle |
| rx_level | input | CNT_W | Current RX FIFO occupancy |
| trig_level | input | CNT_W | Programmed trigger level, in characters |
| wlen_sel | input | 2 | Character width code: 0..3 select 5..8 data bits |
| baud_tick8 | input | 1 | Enable pulse, eight per bit time |
| data_read | input | 1 | Receive data register read strobe |
| char_timeout | output | 1 | Character timeout indication |

## Verification
A counter reloaded with the wrong value, or decremented on cycles without a tick, shows at the port as the flag rising on the wrong tick. The bench catches this in the same window, because it counts ticks exactly and samples the flag one tick before and at the expected edge. A counter that does not stay at zero while the FIFO is empty, or that does not stop at zero, shows as a spurious flag. That flag appears either within one window or after a read when no new window should exist. A wrong flag clear priority shows up in the very cycle where a read and an expiry coincide.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
    localparam int unsigned WL_BASE_BITS  = 5;
    localparam int unsigned WL_MAX_CODE   = 3;
    localparam int unsigned BIT_SCALE     = 7;
    localparam int unsigned STOP_ADJ      = 2;
    localparam int unsigned TICKS_PER_BIT = 8;
    localparam int unsigned FINAL_OFFSET  = 1;

    typedef enum logic [1:0] {
        WLEN5 = 2'd0,
        WLEN6 = 2'd1,
        WLEN7 = 2'd2,
        WLEN8 = 2'd3
    } wlen_e;

    function automatic int unsigned max_window(input int unsigned cnt_w);
        return ((WL_BASE_BITS + WL_MAX_CODE) * BIT_SCALE - STOP_ADJ) * TICKS_PER_BIT
             + ((1 << cnt_w) - 1) * TICKS_PER_BIT + FINAL_OFFSET;
    endfunction
endpackage

// File: rtl/rxto_window.sv
module rxto_window
    import rxto_pkg::*;
#(
    parameter int unsigned CNT_W = 5,
    parameter int unsigned TMR_W = 10
) (
    input  wlen_e             wlen,
    input  logic [CNT_W-1:0]  level,
    input  logic [CNT_W-1:0]  trig,
    output logic [TMR_W-1:0]  window
);
    int unsigned char_bits;
    int unsigned word_term;
    int unsigned gap_chars;
    int unsigned gap_term;

    always_comb begin
        char_bits = WL_BASE_BITS + 32'(wlen);
        word_term = (char_bits * BIT_SCALE - STOP_ADJ) * TICKS_PER_BIT;
        if (trig > level) begin
            gap_chars = 32'(trig) - 32'(level);
        end else begin
            gap_chars = 0;
        end
        gap_term = gap_chars * TICKS_PER_BIT + FINAL_OFFSET;
        window   = TMR_W'(word_term + gap_term);
    end
endmodule

// File: rtl/rxto_timer.sv
module rxto_timer #(
    parameter int unsigned TMR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic              reload,
    input  logic [TMR_W-1:0]  reload_val,
    input  logic              tick,
    output logic [TMR_W-1:0]  remain,
    output logic              expire
);
    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (fifo_empty) begin
            st_d.cnt = '0;
        end else if (reload) begin
            st_d.cnt = reload_val;
        end else if (tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
            expire   = (st_q.cnt == TMR_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign remain = st_q.cnt;
endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);
    typedef struct packed {
        logic pend;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_evt) begin
            st_d.pend = 1'b0;
        end else if (set_evt) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.pend;
endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout
    import rxto_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] trig_level,
    input  logic [1:0]       wlen_sel,
    input  logic             baud_tick8,
    input  logic             data_read,
    output logic             char_timeout
);
    localparam int unsigned TMR_W = $clog2(max_window(CNT_W) + 1);

    logic [TMR_W-1:0] window;
    logic [TMR_W-1:0] remain;
    logic             expire;
    logic             fifo_empty;
    logic             reload;

    assign fifo_empty = (rx_level == '0);
    assign reload     = rx_push | rx_pop;

    rxto_window #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_window (
        .wlen   (wlen_e'(wlen_sel)),
        .level  (rx_level),
        .trig   (trig_level),
        .window (window)
    );

    rxto_timer #(.TMR_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .reload     (reload),
        .reload_val (window),
        .tick       (baud_tick8),
        .remain     (remain),
        .expire     (expire)
    );

    rxto_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (expire),
        .clr_evt (data_read),
        .flag    (char_timeout)
    );
endmodule

// File: rtl/rx_char_timeout_chk.sv
module rx_char_timeout_chk #(
    parameter int unsigned CNT_W = 5,
    parameter int unsigned TMR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_push,
    input logic             rx_pop,
    input logic [CNT_W-1:0] rx_level,
    input logic             baud_tick8,
    input logic             data_read,
    input logic             char_timeout,
    input logic [TMR_W-1:0] remain
);
    // R6
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        data_read |=> !char_timeout);

    // R5
    a_r5_empty_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0 && !char_timeout) |=> !char_timeout);

    // R5
    a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |=> (remain == '0));

    // R7
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (char_timeout && !data_read) |=> char_timeout);

    // R4
    a_r4_reload_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_push || rx_pop) && !char_timeout) |=> !char_timeout);

    // R3
    a_r3_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick8 && !rx_push && !rx_pop && rx_level != '0) |=> $stable(remain));

    // R8
    a_r8_rise_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(char_timeout) |-> ($past(remain) == TMR_W'(1)));
endmodule

bind rx_char_timeout rx_char_timeout_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_push      (rx_push),
    .rx_pop       (rx_pop),
    .rx_level     (rx_level),
    .baud_tick8   (baud_tick8),
    .data_read    (data_read),
    .char_timeout (char_timeout),
    .remain       (remain)
);

// File: tb/sim_rx_char_timeout.sv
`timescale 1ns/1ps
module sim_rx_char_timeout;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_push = 1'b0;
    logic             rx_pop = 1'b0;
    logic [CNT_W-1:0] rx_level = '0;
    logic [CNT_W-1:0] trig_level = '0;
    logic [1:0]       wlen_sel = '0;
    logic             baud_tick8 = 1'b0;
    logic             data_read = 1'b0;
    logic             char_timeout;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_char_timeout #(.CNT_W(CNT_W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_push      (rx_push),
        .rx_pop       (rx_pop),
        .rx_level     (rx_level),
        .trig_level   (trig_level),
        .wlen_sel     (wlen_sel),
        .baud_tick8   (baud_tick8),
        .data_read    (data_read),
        .char_timeout (char_timeout)
    );

    function automatic int win(input int wl, input int trig, input int lvl);
        int gap;
        gap = (trig > lvl) ? (trig - lvl) : 0;
        return ((5 + wl) * 7 - 2) * 8 + gap * 8 + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_push();
        rx_push = 1'b1;
        step();
        rx_push = 1'b0;
    endtask

    task automatic do_pop();
        rx_pop = 1'b1;
        step();
        rx_pop = 1'b0;
    endtask

    task automatic do_read();
        data_read = 1'b1;
        step();
        data_read = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        baud_tick8 = 1'b1;
        for (int i = 0; i < n; i++) step();
        baud_tick8 = 1'b0;
    endtask

    task automatic t_reset();
        chk(char_timeout == 1'b0, "R1 flag low after reset", int'(char_timeout), 0);
    endtask

    task automatic t_window(input int wl, input int trig, input int lvl);
        int w;
        w = win(wl, trig, lvl);
        wlen_sel = 2'(wl);
        trig_level = CNT_W'(trig);
        rx_level = CNT_W'(lvl);
        do_push();
        run_ticks(w - 1);
        chk(char_timeout == 1'b0, "R2 no flag one tick early", int'(char_timeout), 0);
        run_ticks(1);
        chk(char_timeout == 1'b1, "R2 flag at window end", int'(char_timeout), 1);
        do_read();
        chk(char_timeout == 1'b0, "R6 read clears flag", int'(char_timeout), 0);
    endtask

    task automatic t_hold();
        int w;
        wlen_sel = 2'd1; trig_level = 5'd4; rx_level = 5'd3;
        w = win(1, 4, 3);
        do_push();
        for (int i = 0; i < 500; i++) step();
        chk(char_timeout == 1'b0, "R3 no ticks no progress", int'(char_timeout), 0);
        run_ticks(w - 1);
        chk(char_timeout == 1'b0, "R3 held count early", int'(char_timeout), 0);
        run_ticks(1);
        chk(char_timeout == 1'b1, "R3 flag after W ticks", int'(char_timeout), 1);
        do_read();
    endtask

    task automatic t_restart();
        int w1;
        int w2;
        wlen_sel = 2'd0; trig_level = 5'd8; rx_level = 5'd2;
        w1 = win(0, 8, 2);
        do_push();
        run_ticks(w1 - 5);
        rx_level = 5'd1;
        do_pop();
        w2 = win(0, 8, 1);
        run_ticks(w2 - 1);
        chk(char_timeout == 1'b0, "R4 pop restarts window", int'(char_timeout), 0);
        run_ticks(1);
        chk(char_timeout == 1'b1, "R4 flag after reloaded window", int'(char_timeout), 1);
        do_read();
        rx_level = 5'd2;
        do_push();
        run_ticks(w1 - 3);
        do_push();
        run_ticks(w1 - 1);
        chk(char_timeout == 1'b0, "R4 push restarts window", int'(char_timeout), 0);
        run_ticks(1);
        chk(char_timeout == 1'b1, "R4 flag after push reload", int'(char_timeout), 1);
        do_read();
    endtask

    task automatic t_empty();
        wlen_sel = 2'd0; trig_level = 5'd1; rx_level = 5'd0;
        do_push();
        run_ticks(800);
        chk(char_timeout == 1'b0, "R5 empty FIFO never times out", int'(char_timeout), 0);
    endtask

    task automatic t_sticky();
        int w;
        wlen_sel = 2'd2; trig_level = 5'd2; rx_level = 5'd2;
        w = win(2, 2, 2);
        do_push();
        run_ticks(w);
        chk(char_timeout == 1'b1, "R7 flag set", int'(char_timeout), 1);
        rx_level = 5'd0;
        run_ticks(20);
        rx_level = 5'd5;
        run_ticks(20);
        chk(char_timeout == 1'b1, "R7 flag sticky over level change", int'(char_timeout), 1);
        do_read();
        chk(char_timeout == 1'b0, "R6 read clears sticky flag", int'(char_timeout), 0);
    endtask

    task automatic t_read_prio();
        int w;
        wlen_sel = 2'd3; trig_level = 5'd1; rx_level = 5'd1;
        w = win(3, 1, 1);
        do_push();
        run_ticks(w - 1);
        data_read = 1'b1;
        run_ticks(1);
        data_read = 1'b0;
        chk(char_timeout == 1'b0, "R6 read wins over expiry", int'(char_timeout), 0);
        run_ticks(50);
        chk(char_timeout == 1'b0, "R8 no set after lost expiry", int'(char_timeout), 0);
    endtask

    task automatic t_refire();
        int w;
        wlen_sel = 2'd0; trig_level = 5'd0; rx_level = 5'd3;
        w = win(0, 0, 3);
        do_push();
        run_ticks(w);
        chk(char_timeout == 1'b1, "R8 first indication", int'(char_timeout), 1);
        do_read();
        run_ticks(800);
        chk(char_timeout == 1'b0, "R8 single indication per idle", int'(char_timeout), 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_window(0, 1, 1);
        t_window(3, 8, 2);
        t_window(1, 2, 9);
        t_window(2, 31, 1);
        t_hold();
        t_restart();
        t_empty();
        t_sticky();
        t_read_prio();
        t_refire();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule